// File: doc/BRIEF.md
# Configurable Circuit-Switched Mesh Routing Node

This block is a single node of a two-dimensional mesh fabric. It has eight bidirectional ports. Ports 0 to 3 face the neighbouring nodes to the north, south, east and west. Ports 4 to 7 face the adjacent processing elements, and at the mesh edge any of them may face an external I/O link instead. Each port is split into four independent 16-bit lanes, which gives 32 input channels and 32 output channels. Channel index `c = port*4 + lane` names both kinds.

Routing is circuit-switched. A small configuration interface writes one route entry for each output channel, and data carries no header. An entry in unicast mode names one source channel. Several outputs that name the same source form a broadcast. An entry in merge mode collects words from all four lanes of one input port and takes them one at a time in round-robin order. Every output channel is a single register stage, so a word crosses the node in exactly one clock. All 32 outputs may load in the same cycle.

Each channel uses valid/ready flow control. A route change is held back until the output channel it targets has no word waiting. A word already inside the node is therefore never redirected or damaged.

Top module: `mesh_router`

## Requirements
- R1: While reset is asserted, and after its release, every `out_valid` bit is 0 and every route entry is disabled. As a result `in_ready` is 0 on all 32 input channels even when every `in_valid` is high.
- R2: In unicast mode, an entry written as `cfg_addr = o` and `cfg_wdata = {en=1 (bit 6), mode=0 (bit 5), src (bits 4:0)}` connects input channel `src` to output channel `o`. A handshake on `src` at a clock edge makes `out_valid[o]` high after that edge, with the same 16-bit word, and raises no other output.
- R3: When several enabled unicast outputs name the same source, that source is accepted only when every one of those outputs can take a word. All of them then receive the same word on the same edge.
- R4: If one output of a broadcast is holding an unaccepted word, the source's `in_ready` is 0. The other outputs of the broadcast do not receive the next word early.
- R5: An entry with mode=1 (bit 5) merges the four lanes of input port `src[4:2]` into output `o`. Among the valid lanes it grants exactly one per cycle. The search starts at the lane after the one granted last (lane 0 after reset). `in_ready` is high only on the granted lane.
- R6: While `out_valid[o]` is high and `out_ready[o]` is low, the output keeps `out_valid[o]` high and its data unchanged.
- R7: A configuration write to an output that holds a word leaves that word intact. The new entry becomes active only on the first edge at which the output is empty. The output accepts nothing while the write is pending.
- R8: A disabled output never asserts `out_valid`. An input channel that no enabled route names has `in_ready` at 0.
- R9: With a permutation of 32 unicast routes configured, all 32 channels transfer a word on every cycle, each to its own destination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Route entry write strobe |
| cfg_addr | input | 5 | Output channel whose entry is written |
| cfg_wdata | input | 7 | Entry: bit 6 enable, bit 5 merge mode, bits 4:0 source channel |
| in_valid | input | 32 | Per input channel: word offered |
| in_ready | output | 32 | Per input channel: word accepted at this edge when valid |
| in_data | input | 512 | Input words, channel c at bits c*16 +: 16 |
| out_valid | output | 32 | Per output channel: word held |
| out_ready | input | 32 | Per output channel: downstream accepts the word |
| out_data | output | 512 | Output words, channel c at bits c*16 +: 16 |

## Verification
The sharpest interaction in this block is between a route rewrite and a word that is waiting on the same output channel. The bench sets up this collision on purpose. It stalls a merge output with its last word still inside, rewrites that output's entry to a unicast route, and offers a word on the new source at once. The result is judged at the ports: the stalled word must come out unchanged, and the new source must see `in_ready` low through the drain cycle and the commit cycle. Its word must then appear exactly one cycle after it is accepted.

// File: rtl/mr_pkg.sv
package mr_pkg;
  // Mode field of a route entry
  typedef enum logic {
    RT_UNICAST = 1'b0,
    RT_MERGE   = 1'b1
  } route_mode_e;
endpackage

// File: rtl/mr_rr_arb.sv
// Rotating-priority picker over N lanes; N must be a power of two.
module mr_rr_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0]         req,
  input  logic [$clog2(N)-1:0] ptr,
  output logic                 any,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] cand;

  always_comb begin
    any  = 1'b0;
    idx  = ptr;
    cand = ptr;
    for (int k = 0; k < N; k++) begin
      cand = ptr + IW'(k);
      if (!any && req[cand]) begin
        any = 1'b1;
        idx = cand;
      end
    end
  end
endmodule

// File: rtl/mr_route_table.sv
// Shadow and active route entries; a written entry commits when its output is empty.
module mr_route_table
  import mr_pkg::*;
#(
  parameter int NCHAN = 32,
  parameter int SELW  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [SELW-1:0]       cfg_addr,
  input  logic [SELW+1:0]       cfg_wdata,
  input  logic [NCHAN-1:0]      chan_busy,
  output logic [NCHAN-1:0]      act_en,
  output logic [NCHAN-1:0]      act_merge,
  output logic [NCHAN-1:0]      pend,
  output logic [NCHAN*SELW-1:0] act_sel
);
  localparam int EW = SELW + 2;

  logic [NCHAN*EW-1:0] shadow_q, shadow_n;
  logic [NCHAN*EW-1:0] active_q, active_n;
  logic [NCHAN-1:0]    pend_q, pend_n;

  always_comb begin
    shadow_n = shadow_q;
    active_n = active_q;
    pend_n   = pend_q;
    for (int o = 0; o < NCHAN; o++) begin
      if (cfg_we && (cfg_addr == SELW'(o))) begin
        shadow_n[o*EW +: EW] = cfg_wdata;
        pend_n[o]            = 1'b1;
      end else if (pend_q[o] && !chan_busy[o]) begin
        active_n[o*EW +: EW] = shadow_q[o*EW +: EW];
        pend_n[o]            = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      pend_q   <= '0;
    end else begin
      shadow_q <= shadow_n;
      active_q <= active_n;
      pend_q   <= pend_n;
    end
  end

  assign pend = pend_q;

  for (genvar o = 0; o < NCHAN; o++) begin : g_ent
    assign act_sel[o*SELW +: SELW] = active_q[o*EW +: SELW];
    assign act_merge[o] = (route_mode_e'(active_q[o*EW + SELW]) == RT_MERGE);
    assign act_en[o]    = active_q[o*EW + SELW + 1];
  end
endmodule

// File: rtl/mr_out_stage.sv
// One output channel register plus its merge rotation pointer.
module mr_out_stage #(
  parameter int DW = 16,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          merge_load,
  input  logic [LW-1:0] load_lane,
  input  logic [DW-1:0] load_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [LW-1:0] ptr
);
  logic          valid_q, valid_n;
  logic [LW-1:0] ptr_q, ptr_n;
  logic [DW-1:0] data_q;

  always_comb begin
    valid_n = load | (valid_q & ~out_ready);
    ptr_n   = ptr_q;
    if (load && merge_load) begin
      ptr_n = load_lane + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ptr_q   <= '0;
    end else begin
      valid_q <= valid_n;
      ptr_q   <= ptr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      data_q <= load_data;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign ptr       = ptr_q;
endmodule

// File: rtl/mesh_router.sv
module mesh_router #(
  parameter int NPORT = 8,
  parameter int NLANE = 4,
  parameter int DW    = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [$clog2(NPORT*NLANE)-1:0]   cfg_addr,
  input  logic [$clog2(NPORT*NLANE)+1:0]   cfg_wdata,
  input  logic [NPORT*NLANE-1:0]           in_valid,
  output logic [NPORT*NLANE-1:0]           in_ready,
  input  logic [NPORT*NLANE*DW-1:0]        in_data,
  output logic [NPORT*NLANE-1:0]           out_valid,
  input  logic [NPORT*NLANE-1:0]           out_ready,
  output logic [NPORT*NLANE*DW-1:0]        out_data
);
  localparam int NCHAN = NPORT * NLANE;
  localparam int SELW  = $clog2(NCHAN);
  localparam int LANEW = $clog2(NLANE);

  // Reset: asserted asynchronously, released on the second clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [NCHAN-1:0]      act_en, act_merge, pend;
  logic [NCHAN*SELW-1:0] act_sel;

  mr_route_table #(
    .NCHAN (NCHAN),
    .SELW  (SELW)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .chan_busy (out_valid),
    .act_en    (act_en),
    .act_merge (act_merge),
    .pend      (pend),
    .act_sel   (act_sel)
  );

  logic [NCHAN-1:0]       free, src_ok, load, arb_any, fire, has_dst, blocked;
  logic [NCHAN*SELW-1:0]  src_of;
  logic [NCHAN*LANEW-1:0] arb_idx, rr_ptr;
  logic [NCHAN*DW-1:0]    load_data;

  for (genvar o = 0; o < NCHAN; o++) begin : g_out
    logic [SELW-1:0]  sel_o, mbase;
    logic [NLANE-1:0] mreq;

    assign sel_o = act_sel[o*SELW +: SELW];
    assign mbase = {sel_o[SELW-1:LANEW], {LANEW{1'b0}}};
    assign mreq  = in_valid[mbase +: NLANE];

    mr_rr_arb #(
      .N (NLANE)
    ) u_arb (
      .req (mreq),
      .ptr (rr_ptr[o*LANEW +: LANEW]),
      .any (arb_any[o]),
      .idx (arb_idx[o*LANEW +: LANEW])
    );

    assign src_of[o*SELW +: SELW] = act_merge[o]
                                  ? (mbase | SELW'(arb_idx[o*LANEW +: LANEW]))
                                  : sel_o;
    assign src_ok[o] = act_en[o] & (~act_merge[o] | arb_any[o]);
    assign free[o]   = act_en[o] & ~pend[o] & (~out_valid[o] | out_ready[o]);
    assign load[o]   = free[o] & src_ok[o] & fire[src_of[o*SELW +: SELW]];
    assign load_data[o*DW +: DW] = in_data[src_of[o*SELW +: SELW]*DW +: DW];

    mr_out_stage #(
      .DW (DW),
      .LW (LANEW)
    ) u_stage (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .load       (load[o]),
      .merge_load (act_merge[o]),
      .load_lane  (arb_idx[o*LANEW +: LANEW]),
      .load_data  (load_data[o*DW +: DW]),
      .out_ready  (out_ready[o]),
      .out_valid  (out_valid[o]),
      .out_data   (out_data[o*DW +: DW]),
      .ptr        (rr_ptr[o*LANEW +: LANEW])
    );
  end

  // A source moves only when every output currently taking it can load.
  always_comb begin
    has_dst = '0;
    blocked = '0;
    for (int s = 0; s < NCHAN; s++) begin
      for (int o = 0; o < NCHAN; o++) begin
        if (src_ok[o] && (src_of[o*SELW +: SELW] == SELW'(s))) begin
          has_dst[s] = 1'b1;
          if (!free[o]) blocked[s] = 1'b1;
        end
      end
    end
  end

  assign fire     = in_valid & has_dst & ~blocked;
  assign in_ready = has_dst & ~blocked;
endmodule

// File: rtl/mesh_router_chk.sv
module mesh_router_chk #(
  parameter int NCHAN = 32,
  parameter int SELW  = 5,
  parameter int DW    = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NCHAN-1:0]      in_valid,
  input logic [NCHAN-1:0]      in_ready,
  input logic [NCHAN-1:0]      out_valid,
  input logic [NCHAN-1:0]      out_ready,
  input logic [NCHAN*DW-1:0]   out_data,
  input logic [NCHAN-1:0]      act_en,
  input logic [NCHAN-1:0]      act_merge,
  input logic [NCHAN*SELW-1:0] act_sel
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) !rst_n |-> (out_valid == '0));

  // R2
  xfer_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(in_valid & in_ready)) |=> (|out_valid));

  for (genvar o = 0; o < NCHAN; o++) begin : g_chk
    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && !out_ready[o]) |=> (out_valid[o] && $stable(out_data[o*DW +: DW])));

    // R8
    dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_en[o] && !out_valid[o]) |=> !out_valid[o]);

    // R7
    route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] |=> $stable({act_en[o], act_merge[o], act_sel[o*SELW +: SELW]}));

    // R3
    fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_en[o] && !act_merge[o] && in_valid[act_sel[o*SELW +: SELW]]
       && in_ready[act_sel[o*SELW +: SELW]]) |=> out_valid[o]);
  end
endmodule

bind mesh_router mesh_router_chk #(
  .NCHAN (NCHAN),
  .SELW  (SELW),
  .DW    (DW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .act_en    (act_en),
  .act_merge (act_merge),
  .act_sel   (act_sel)
);

// File: tb/mesh_router_tb.sv
module mesh_router_tb;
  localparam int NCH = 32;
  localparam int DW  = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we;
  logic [4:0]        cfg_addr;
  logic [6:0]        cfg_wdata;
  logic [NCH-1:0]    in_valid, in_ready, out_valid, out_ready;
  logic [NCH*DW-1:0] in_data, out_data;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  mesh_router u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  // {source[25:21], destination[20:16], word[15:0]}
  localparam logic [25:0] VEC [8] = '{
    {5'd0,  5'd31, 16'h1234},
    {5'd31, 5'd0,  16'hFFFF},
    {5'd7,  5'd16, 16'h0000},
    {5'd16, 5'd7,  16'hA5A5},
    {5'd3,  5'd3,  16'h5A5A},
    {5'd12, 5'd25, 16'h8001},
    {5'd25, 5'd12, 16'h7FFE},
    {5'd19, 5'd4,  16'hC3C3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input int a, input logic en, input logic mg, input int sel);
    cfg_we    = 1'b1;
    cfg_addr  = a[4:0];
    cfg_wdata = {en, mg, sel[4:0]};
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R9 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int src, dst, mism;
    logic [15:0] d;
    int lanes [5];
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = '0; in_data = '0; out_ready = '1;
    #1;
    chk("R1 reset out_valid", out_valid, 32'h0);
    chk("R1 reset in_ready", in_ready, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: nothing routed, all inputs offered
    in_valid = '1;
    for (int s = 0; s < NCH; s++) in_data[s*DW +: DW] = 16'(s * 97);
    #1 chk("R8 unrouted in_ready", in_ready, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R8 disabled out_valid", out_valid, 32'h0);
    in_valid = '0;

    // R2: unicast vector table
    for (int v = 0; v < 8; v++) begin
      src = int'(VEC[v][25:21]);
      dst = int'(VEC[v][20:16]);
      d   = VEC[v][15:0];
      cfg(dst, 1'b1, 1'b0, src);
      in_valid[src] = 1'b1;
      in_data[src*DW +: DW] = d;
      #1 chk("R2 in_ready", 32'(in_ready[src]), 32'h1);
      @(posedge clk); @(negedge clk);
      in_valid[src] = 1'b0;
      chk("R2 only dst valid", out_valid, 32'h1 << dst);
      chk("R2 word", 32'(out_data[dst*DW +: DW]), 32'(d));
      cfg(dst, 1'b0, 1'b0, 0);
    end

    // R3 / R4 / R6: broadcast source 5 to outputs 0, 9, 30
    cfg(0, 1'b1, 1'b0, 5);
    cfg(9, 1'b1, 1'b0, 5);
    cfg(30, 1'b1, 1'b0, 5);
    in_valid[5] = 1'b1;
    in_data[5*DW +: DW] = 16'hB0A5;
    @(posedge clk); @(negedge clk);
    chk("R3 bcast valid", out_valid, (32'h1 << 0) | (32'h1 << 9) | (32'h1 << 30));
    chk("R3 bcast out0", 32'(out_data[0*DW +: DW]), 32'hB0A5);
    chk("R3 bcast out9", 32'(out_data[9*DW +: DW]), 32'hB0A5);
    chk("R3 bcast out30", 32'(out_data[30*DW +: DW]), 32'hB0A5);
    out_ready[9] = 1'b0;
    in_data[5*DW +: DW] = 16'h5B0B;
    #1 chk("R4 stalled source ready", 32'(in_ready[5]), 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R4 no early copy", out_valid, 32'h1 << 9);
    chk("R6 held word", 32'(out_data[9*DW +: DW]), 32'hB0A5);
    out_ready[9] = 1'b1;
    #1 chk("R3 source ready again", 32'(in_ready[5]), 32'h1);
    @(posedge clk); @(negedge clk);
    in_valid[5] = 1'b0;
    chk("R3 second word out0", 32'(out_data[0*DW +: DW]), 32'h5B0B);
    chk("R3 second word out9", 32'(out_data[9*DW +: DW]), 32'h5B0B);
    chk("R3 second word out30", 32'(out_data[30*DW +: DW]), 32'h5B0B);
    cfg(0, 1'b0, 1'b0, 0);
    cfg(9, 1'b0, 1'b0, 0);
    cfg(30, 1'b0, 1'b0, 0);

    // R5: merge port 2 (channels 8..11) into output 12; lane 1 idle
    cfg(12, 1'b1, 1'b1, 8);
    for (int s = 8; s < 12; s++) in_data[s*DW +: DW] = 16'(16'hA000 + s);
    in_valid[8] = 1'b1; in_valid[10] = 1'b1; in_valid[11] = 1'b1;
    lanes = '{0, 2, 3, 0, 2};
    for (int k = 0; k < 5; k++) begin
      #1 chk("R5 grant one-hot", 32'(in_ready[11:8]), 32'h1 << lanes[k]);
      @(posedge clk); @(negedge clk);
      chk("R5 merge valid", 32'(out_valid[12]), 32'h1);
      chk("R5 merge order", 32'(out_data[12*DW +: DW]), 32'(16'hA008 + lanes[k]));
    end
    in_valid = '0;
    out_ready[12] = 1'b0;

    // R7: rewrite output 12 while its word is waiting
    cfg(12, 1'b1, 1'b0, 20);
    chk("R7 word kept valid", 32'(out_valid[12]), 32'h1);
    chk("R7 word kept data", 32'(out_data[12*DW +: DW]), 32'hA00A);
    in_valid[20] = 1'b1;
    in_data[20*DW +: DW] = 16'h7E57;
    out_ready[12] = 1'b1;
    #1 chk("R7 pending blocks source", 32'(in_ready[20]), 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R7 drained", 32'(out_valid[12]), 32'h0);
    chk("R7 still pending", 32'(in_ready[20]), 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R7 committed", 32'(in_ready[20]), 32'h1);
    @(posedge clk); @(negedge clk);
    in_valid[20] = 1'b0;
    chk("R7 new route valid", 32'(out_valid[12]), 32'h1);
    chk("R7 new route word", 32'(out_data[12*DW +: DW]), 32'h7E57);

    // R9: full permutation, back-to-back words
    for (int o = 0; o < NCH; o++) cfg(o, 1'b1, 1'b0, (o * 5 + 3) % NCH);
    for (int k = 0; k < 3; k++) begin
      for (int s = 0; s < NCH; s++) in_data[s*DW +: DW] = {8'(s), 8'(k)};
      in_valid = '1;
      #1 chk("R9 all ready", in_ready, 32'hFFFF_FFFF);
      @(posedge clk); @(negedge clk);
      chk("R9 all valid", out_valid, 32'hFFFF_FFFF);
      mism = 0;
      for (int o = 0; o < NCH; o++) begin
        if (out_data[o*DW +: DW] !== {8'((o * 5 + 3) % NCH), 8'(k)}) mism++;
      end
      chk("R9 words mismatched", 32'(mism), 32'h0);
    end
    in_valid = '0;

    // R1: reset in mid-run clears routes and outputs
    @(negedge clk) rst_n = 1'b0;
    #1 chk("R1 async clear", out_valid, 32'h0);
    in_valid = '1;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk("R1 routes cleared", in_ready, 32'h0);
    chk("R1 outputs quiet", out_valid, 32'h0);
    in_valid = '0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule